// File: doc/BRIEF.md
# Voltage-Frequency Level Sequencer

This block picks the operating level of an interconnect clock domain from a choice of five levels and steps the supply and the clock to that level in a safe order. Level 0 is the fastest and level 4 the slowest. Each level has a clock rate and a supply voltage code.

On every sampling tick it reads a busy count and a total cycle count from each of several activity monitors. It keeps the monitor with the largest busy count and multiplies that count by four, so that 25% utilization counts as a saturated bus. It then compares the scaled value with two fractions of the total count and chooses a target level. A change of level is carried out through two request/acknowledge ports, one for the regulator and one for the clock generator. Each port also has an error input.

A suspend pulse locks out decisions and drives the domain to the fastest level. A resume pulse removes the lock.

Top module: `vf_level_seq`

## Requirements
- R1: After reset the current level is 2 (160 MHz). Both request outputs are low and `locked` is low.
- R2: `cur_mhz` reads 266, 200, 160, 133 and 100 for current levels 0 to 4. While a voltage request is up, `volt_code` equals V_SLOW + V_STEP*(4 - target); with the defaults that gives 120, 115, 110, 105 and 100 for levels 0 to 4. `clk_lvl` carries the target level index.
- R3: The monitor with the strictly largest busy count supplies both the busy and total counts. On a tie the lowest index wins. Monitor i occupies bits [i*CNT_W +: CNT_W] of `mon_busy` and of `mon_total`.
- R4: Let S = 400*busy. If S > HI_PCT*total, the target is level 0. If S < LO_PCT*total, the target is one level slower, but never slower than level 4. Otherwise the current level is kept. The defaults are HI_PCT=90 and LO_PCT=50.
- R5: When the target equals the current level, no voltage or clock request is issued.
- R6: For a faster target, the voltage request is acknowledged before the clock request starts. For a slower target, the clock request is acknowledged before the voltage request starts. Only one request is up at a time. A request stays high with a stable code until ack or err is sampled high.
- R7: An err on either port ends the sequence at once and returns the controller to idle. No further request is issued and the current level is left unchanged.
- R8: A decision is taken only on a tick that arrives while the controller is idle. A tick that arrives during a transition is dropped.
- R9: A suspend pulse sets `locked` and moves the domain to level 0, voltage first. While `locked` is set, ticks have no effect.
- R10: A resume pulse clears `locked`, and later ticks take decisions again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampling period pulse |
| suspend | input | 1 | Suspend-prepare pulse |
| resume | input | 1 | Resume pulse |
| mon_busy | input | NUM_MON*CNT_W | Busy counts, one field per monitor |
| mon_total | input | NUM_MON*CNT_W | Total cycle counts, one field per monitor |
| volt_req | output | 1 | Voltage change request |
| volt_code | output | VOLT_W | Requested voltage code |
| volt_ack | input | 1 | Voltage change done |
| volt_err | input | 1 | Voltage change failed |
| clk_req | output | 1 | Clock change request |
| clk_lvl | output | 3 | Requested level index |
| clk_ack | input | 1 | Clock change done |
| clk_err | input | 1 | Clock change failed |
| cur_lvl | output | 3 | Committed current level |
| cur_mhz | output | 9 | Clock rate of the current level in MHz |
| locked | output | 1 | Decisions are locked out by suspend |

## Verification
The bench builds the block with two monitors of 16-bit counts, thresholds of 90% and 50%, and voltage codes 100 + 5 per level. Two monitors are enough to show that the busier one is chosen: the other monitor's counts would lead to a different decision. 16-bit counts allow exact threshold edges, such as busy 225 against busy 226 over a total of 1000. The distinct voltage codes make each level's code visible on the regulator port.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int NUM_LVL = 5;
  localparam int LVL_W   = 3;
  localparam int MHZ_W   = 9;
  localparam logic [LVL_W-1:0] TOP_LVL  = 3'd0;
  localparam logic [LVL_W-1:0] SLOW_LVL = 3'(NUM_LVL - 1);
  localparam logic [LVL_W-1:0] BOOT_LVL = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAISE_V,
    ST_RAISE_C,
    ST_LOWER_C,
    ST_LOWER_V
  } seq_state_t;

  function automatic logic [MHZ_W-1:0] lvl_mhz(input logic [LVL_W-1:0] l);
    case (l)
      3'd0:    lvl_mhz = 9'd266;
      3'd1:    lvl_mhz = 9'd200;
      3'd2:    lvl_mhz = 9'd160;
      3'd3:    lvl_mhz = 9'd133;
      default: lvl_mhz = 9'd100;
    endcase
  endfunction
endpackage

// File: rtl/vfs_load_pick.sv
module vfs_load_pick #(
  parameter int NUM_MON = 2,
  parameter int CNT_W   = 16
) (
  input  logic [NUM_MON*CNT_W-1:0] mon_busy,
  input  logic [NUM_MON*CNT_W-1:0] mon_total,
  output logic [CNT_W-1:0]         sel_busy,
  output logic [CNT_W-1:0]         sel_total
);
  logic [CNT_W-1:0] busy_a  [NUM_MON];
  logic [CNT_W-1:0] total_a [NUM_MON];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MON; gi++) begin : g_unpack
      assign busy_a[gi]  = mon_busy[gi*CNT_W +: CNT_W];
      assign total_a[gi] = mon_total[gi*CNT_W +: CNT_W];
    end
  endgenerate

  // strict compare keeps the lowest index on ties
  always_comb begin
    sel_busy  = busy_a[0];
    sel_total = total_a[0];
    for (int i = 1; i < NUM_MON; i++) begin
      if (busy_a[i] > sel_busy) begin
        sel_busy  = busy_a[i];
        sel_total = total_a[i];
      end
    end
  end
endmodule

// File: rtl/vfs_level_judge.sv
module vfs_level_judge
  import vfs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HI_PCT = 90,
  parameter int LO_PCT = 50
) (
  input  logic [CNT_W-1:0] busy,
  input  logic [CNT_W-1:0] total,
  input  logic [LVL_W-1:0] cur,
  output logic [LVL_W-1:0] target
);
  localparam int PW = CNT_W + 10;

  logic [PW-1:0] scaled_pct;
  logic [PW-1:0] hi_mark;
  logic [PW-1:0] lo_mark;

  // busy * 4 (saturation) * 100 (percent)
  assign scaled_pct = PW'(busy) * PW'(400);
  assign hi_mark    = PW'(total) * PW'(HI_PCT);
  assign lo_mark    = PW'(total) * PW'(LO_PCT);

  always_comb begin
    target = cur;
    if (scaled_pct > hi_mark) begin
      target = TOP_LVL;
    end else if (scaled_pct < lo_mark) begin
      if (cur < SLOW_LVL) target = cur + 3'd1;
    end
  end
endmodule

// File: rtl/vfs_step_fsm.sv
module vfs_step_fsm
  import vfs_pkg::*;
#(
  parameter int VOLT_W = 8,
  parameter int V_SLOW = 100,
  parameter int V_STEP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              suspend,
  input  logic              resume,
  input  logic [LVL_W-1:0]  judged,
  output logic [LVL_W-1:0]  cur_lvl,
  output logic              locked,
  output logic              volt_req,
  output logic [VOLT_W-1:0] volt_code,
  input  logic              volt_ack,
  input  logic              volt_err,
  output logic              clk_req,
  output logic [LVL_W-1:0]  clk_lvl,
  input  logic              clk_ack,
  input  logic              clk_err
);
  seq_state_t       state_q, state_d;
  logic [LVL_W-1:0] cur_q, cur_d;
  logic [LVL_W-1:0] tgt_q, tgt_d;
  logic             lock_q, lock_d;
  logic             pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    tgt_d   = tgt_q;
    lock_d  = lock_q;
    pend_d  = pend_q;

    if (suspend) begin
      lock_d = 1'b1;
      pend_d = 1'b1;
    end else if (resume) begin
      lock_d = 1'b0;
      pend_d = 1'b0;
    end

    case (state_q)
      ST_IDLE: begin
        if (pend_q || suspend) begin
          pend_d = 1'b0;
          if (cur_q != TOP_LVL) begin
            tgt_d   = TOP_LVL;
            state_d = ST_RAISE_V;
          end
        end else if (tick && !lock_q && judged != cur_q) begin
          tgt_d   = judged;
          state_d = (judged < cur_q) ? ST_RAISE_V : ST_LOWER_C;
        end
      end
      ST_RAISE_V: begin
        if (volt_err)      state_d = ST_IDLE;
        else if (volt_ack) state_d = ST_RAISE_C;
      end
      ST_RAISE_C: begin
        if (clk_err) begin
          state_d = ST_IDLE;
        end else if (clk_ack) begin
          state_d = ST_IDLE;
          cur_d   = tgt_q;
        end
      end
      ST_LOWER_C: begin
        if (clk_err)      state_d = ST_IDLE;
        else if (clk_ack) state_d = ST_LOWER_V;
      end
      ST_LOWER_V: begin
        if (volt_err) begin
          state_d = ST_IDLE;
        end else if (volt_ack) begin
          state_d = ST_IDLE;
          cur_d   = tgt_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= BOOT_LVL;
      tgt_q   <= BOOT_LVL;
      lock_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      lock_q  <= lock_d;
      pend_q  <= pend_d;
    end
  end

  assign cur_lvl   = cur_q;
  assign locked    = lock_q;
  assign volt_req  = (state_q == ST_RAISE_V) || (state_q == ST_LOWER_V);
  assign clk_req   = (state_q == ST_RAISE_C) || (state_q == ST_LOWER_C);
  assign clk_lvl   = tgt_q;
  assign volt_code = VOLT_W'(V_SLOW + V_STEP * (int'(SLOW_LVL) - int'(tgt_q)));
endmodule

// File: rtl/vf_level_seq.sv
module vf_level_seq
  import vfs_pkg::*;
#(
  parameter int NUM_MON = 2,
  parameter int CNT_W   = 16,
  parameter int HI_PCT  = 90,
  parameter int LO_PCT  = 50,
  parameter int VOLT_W  = 8,
  parameter int V_SLOW  = 100,
  parameter int V_STEP  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     suspend,
  input  logic                     resume,
  input  logic [NUM_MON*CNT_W-1:0] mon_busy,
  input  logic [NUM_MON*CNT_W-1:0] mon_total,
  output logic                     volt_req,
  output logic [VOLT_W-1:0]        volt_code,
  input  logic                     volt_ack,
  input  logic                     volt_err,
  output logic                     clk_req,
  output logic [2:0]               clk_lvl,
  input  logic                     clk_ack,
  input  logic                     clk_err,
  output logic [2:0]               cur_lvl,
  output logic [8:0]               cur_mhz,
  output logic                     locked
);
  logic [CNT_W-1:0] sel_busy;
  logic [CNT_W-1:0] sel_total;
  logic [LVL_W-1:0] judged;

  vfs_load_pick #(.NUM_MON(NUM_MON), .CNT_W(CNT_W)) u_pick (
    .mon_busy  (mon_busy),
    .mon_total (mon_total),
    .sel_busy  (sel_busy),
    .sel_total (sel_total)
  );

  vfs_level_judge #(.CNT_W(CNT_W), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT)) u_judge (
    .busy   (sel_busy),
    .total  (sel_total),
    .cur    (cur_lvl),
    .target (judged)
  );

  vfs_step_fsm #(.VOLT_W(VOLT_W), .V_SLOW(V_SLOW), .V_STEP(V_STEP)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .suspend   (suspend),
    .resume    (resume),
    .judged    (judged),
    .cur_lvl   (cur_lvl),
    .locked    (locked),
    .volt_req  (volt_req),
    .volt_code (volt_code),
    .volt_ack  (volt_ack),
    .volt_err  (volt_err),
    .clk_req   (clk_req),
    .clk_lvl   (clk_lvl),
    .clk_ack   (clk_ack),
    .clk_err   (clk_err)
  );

  assign cur_mhz = lvl_mhz(cur_lvl);
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int VOLT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              volt_req,
  input logic [VOLT_W-1:0] volt_code,
  input logic              volt_ack,
  input logic              volt_err,
  input logic              clk_req,
  input logic [2:0]        clk_lvl,
  input logic              clk_ack,
  input logic              cur_lvl_dummy,
  input logic [2:0]        cur_lvl
);
  assert_lvl_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl <= 3'd4);

  assert_one_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(volt_req && clk_req));

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req && !volt_ack && !volt_err) |=> (volt_req && $stable(volt_code)));

  assert_raise_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_req) && clk_lvl < cur_lvl) |-> $past(volt_ack));

  assert_lower_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(volt_req) |-> ($past(clk_ack) || clk_lvl < cur_lvl));

  assert_commit_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_lvl) |-> $past(clk_ack || volt_ack));
endmodule

bind vf_level_seq vfs_checker #(.VOLT_W(VOLT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .volt_req      (volt_req),
  .volt_code     (volt_code),
  .volt_ack      (volt_ack),
  .volt_err      (volt_err),
  .clk_req       (clk_req),
  .clk_lvl       (clk_lvl),
  .clk_ack       (clk_ack),
  .cur_lvl_dummy (locked),
  .cur_lvl       (cur_lvl)
);

// File: tb/vf_level_seq_test.sv
`timescale 1ns/1ps
module vf_level_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, suspend, resume;
  logic [31:0] mon_busy, mon_total;
  logic        volt_req, volt_ack, volt_err;
  logic [7:0]  volt_code;
  logic        clk_req, clk_ack, clk_err;
  logic [2:0]  clk_lvl, cur_lvl;
  logic [8:0]  cur_mhz;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit inj_volt_err = 0;
  bit inj_clk_err  = 0;

  // scoreboard: kind 0 = voltage request, 1 = clock request
  int    exp_kind[$];
  int    exp_val[$];
  string exp_tag[$];

  always #4 clk = ~clk;

  vf_level_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .suspend(suspend), .resume(resume),
    .mon_busy(mon_busy), .mon_total(mon_total),
    .volt_req(volt_req), .volt_code(volt_code), .volt_ack(volt_ack), .volt_err(volt_err),
    .clk_req(clk_req), .clk_lvl(clk_lvl), .clk_ack(clk_ack), .clk_err(clk_err),
    .cur_lvl(cur_lvl), .cur_mhz(cur_mhz), .locked(locked)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int vcode(input int l);
    return 100 + 5 * (4 - l);
  endfunction

  task automatic expect_item(input int kind, input int val, input string tag);
    exp_kind.push_back(kind);
    exp_val.push_back(val);
    exp_tag.push_back(tag);
  endtask

  task automatic sb_pop(input int kind, input int val);
    if (exp_kind.size() == 0) begin
      check(0, kind == 0 ? "R5 unexpected volt req" : "R5 unexpected clk req", val, -1);
    end else begin
      int    k = exp_kind.pop_front();
      int    v = exp_val.pop_front();
      string t = exp_tag.pop_front();
      check(k == kind, {t, " request kind"}, kind, k);
      check(v == val, {t, " request value"}, val, v);
    end
  endtask

  // monitor and responder
  initial begin
    bit vseen = 0, cseen = 0;
    int vwait = 0, cwait = 0;
    volt_ack = 0; volt_err = 0; clk_ack = 0; clk_err = 0;
    forever begin
      @(negedge clk);
      volt_ack = 0; volt_err = 0; clk_ack = 0; clk_err = 0;
      if (!volt_req) vseen = 0;
      if (!clk_req)  cseen = 0;
      if (volt_req && !vseen) begin
        vseen = 1; vwait = 2;
        sb_pop(0, int'(volt_code));
      end else if (volt_req && vwait > 0) begin
        vwait--;
        if (vwait == 0) begin
          if (inj_volt_err) begin volt_err = 1; inj_volt_err = 0; end
          else volt_ack = 1;
        end
      end
      if (clk_req && !cseen) begin
        cseen = 1; cwait = 2;
        sb_pop(1, int'(clk_lvl));
      end else if (clk_req && cwait > 0) begin
        cwait--;
        if (cwait == 0) begin
          if (inj_clk_err) begin clk_err = 1; inj_clk_err = 0; end
          else clk_ack = 1;
        end
      end
    end
  end

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic settle(input string tag, input int lvl);
    repeat (16) @(negedge clk);
    check(exp_kind.size() == 0, {tag, " pending items"}, exp_kind.size(), 0);
    check(cur_lvl == 3'(lvl), {tag, " level"}, cur_lvl, lvl);
  endtask

  task automatic load(input int b0, input int t0, input int b1, input int t1);
    mon_busy  = {16'(b1), 16'(b0)};
    mon_total = {16'(t1), 16'(t0)};
  endtask

  initial begin
    tick = 0; suspend = 0; resume = 0; rst_n = 0;
    load(0, 1000, 0, 1000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cur_lvl == 3'd2, "R1 reset level", cur_lvl, 2);
    check(cur_mhz == 9'd160, "R2 reset mhz", cur_mhz, 160);
    check(!volt_req && !clk_req, "R1 no request", volt_req + clk_req, 0);
    check(!locked, "R1 unlocked", locked, 0);

    // R3: monitor 1 busier (240/1000 -> up), monitor 0 alone would hold (10/50)
    load(10, 50, 240, 1000);
    expect_item(0, vcode(0), "R6 raise volt first");
    expect_item(1, 0, "R6 raise clk second");
    pulse_tick();
    settle("R3 busier monitor", 0);
    check(cur_mhz == 9'd266, "R2 mhz level0", cur_mhz, 266);

    // R5: mid band, no request
    load(200, 1000, 0, 1000);
    pulse_tick();
    settle("R5 hold", 0);

    // R4: low load steps down one level at a time, clock first
    load(50, 1000, 50, 1000);
    for (int l = 1; l <= 4; l++) begin
      expect_item(1, l, "R6 lower clk first");
      expect_item(0, vcode(l), "R6 lower volt second");
      pulse_tick();
      settle("R4 step down", l);
    end
    check(cur_mhz == 9'd100, "R2 mhz level4", cur_mhz, 100);
    pulse_tick();
    settle("R4 floor at slowest", 4);

    // R4 threshold edge: 225*400 == 90% of 1000*100 -> hold; 226 -> up
    load(225, 1000, 225, 1000);
    pulse_tick();
    settle("R4 at high edge", 4);
    load(226, 1000, 0, 1000);
    expect_item(0, vcode(0), "R4 above high edge volt");
    expect_item(1, 0, "R4 above high edge clk");
    pulse_tick();
    settle("R4 above high edge", 0);

    // R7: clock error while lowering
    load(50, 1000, 0, 1000);
    inj_clk_err = 1;
    expect_item(1, 1, "R7 clk err step");
    pulse_tick();
    settle("R7 clk err keeps level", 0);
    expect_item(1, 1, "R7 prep clk");
    expect_item(0, vcode(1), "R7 prep volt");
    pulse_tick();
    settle("R7 prep", 1);
    load(900, 1000, 0, 1000);
    inj_volt_err = 1;
    expect_item(0, vcode(0), "R7 volt err step");
    pulse_tick();
    settle("R7 volt err keeps level", 1);

    // R8: second tick during transition dropped
    load(50, 1000, 0, 1000);
    expect_item(1, 2, "R8 clk");
    expect_item(0, vcode(2), "R8 volt");
    pulse_tick();
    repeat (2) @(negedge clk);
    pulse_tick();
    settle("R8 tick during transition", 2);
    check(cur_mhz == 9'd160, "R2 mhz level2", cur_mhz, 160);

    // R9: suspend forces level 0 voltage first and locks
    expect_item(0, vcode(0), "R9 suspend volt");
    expect_item(1, 0, "R9 suspend clk");
    @(negedge clk); suspend = 1;
    @(negedge clk); suspend = 0;
    check(locked, "R9 locked", locked, 1);
    settle("R9 suspend", 0);
    pulse_tick();
    settle("R9 tick while locked", 0);
    check(locked, "R9 still locked", locked, 1);

    // R10: resume re-enables decisions
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
    check(!locked, "R10 unlocked", locked, 0);
    expect_item(1, 1, "R10 clk");
    expect_item(0, vcode(1), "R10 volt");
    pulse_tick();
    settle("R10 decisions resume", 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule